// File: doc/BRIEF.md
# CAN Error Status Flag Register

This block is the 8-bit flag register of a CAN controller. The transmit and receive error counters come in from the protocol engine. The block sorts them into a 2-bit receiver bus level and a 2-bit transmitter bus level.

Whenever the sorted level differs from the level last captured, the block raises a latched change flag and captures the new level. While that flag is set, the captured level stays frozen, however far the counters move. Software reads the captured pair knowing that it belongs to the change that raised the flag. When software clears the flag, the level is compared again on the next clock.

The register also holds three event flags:
- a wake flag, raised by bus activity seen while asleep with wake-up enabled;
- an overrun flag;
- a receive-full flag.

Flags are cleared by writing one. While initialization mode is in force, the flags are held at zero and every write is ignored. Three interrupt outputs gate the wake, change and overrun flags with their enable inputs.

Top module: `can_err_flag_reg`

## Requirements
- R1: After a synchronous reset, rd_data reads 0x00 and irq_wake, irq_err and irq_ovr are low.
- R2: rd_data carries, from bit 7 down to bit 0: the wake flag, the change flag, the receiver level in [5:4], the transmitter level in [3:2], the overrun flag and the receive-full flag. Writes never alter bits [5:2].
- R3: The receiver level is computed as follows. It is 2'b11 when tec >= 256. Otherwise it is 2'b10 when rec >= 128, 2'b01 when 96 <= rec <= 127, and 2'b00 when rec < 96.
- R4: The transmitter level is 2'b11 when tec >= 256, 2'b10 for 128..255, 2'b01 for 96..127, and 2'b00 below 96.
- R5: With the change flag clear and outside initialization mode, the first clock edge at which a computed level differs from its captured level does two things together: it sets the change flag (bit 6) and it loads both captured levels.
- R6: While the change flag is set, bits [5:2] hold their value whatever tec and rec do.
- R7: At the edge after the change flag is cleared, the levels are compared again. If they differ, the flag sets again and the captured levels update.
- R8: A write with wr_en high clears each of bits 7, 6, 1 and 0 whose wr_data bit is 1. A data bit of 0 leaves its flag unchanged.
- R9: When a set event and a write-one clear reach the same flag at the same edge, the flag ends up set.
- R10: The wake flag sets at an edge where bus_activity, sleep_mode and wake_en are all high. If any one of the three is low, bus_activity leaves it unchanged.
- R11: While init_req and init_ack are both high, bits 7, 6, 1 and 0 read 0, and writes and events have no effect. Bits [5:2] keep their value and do not update. If only one of init_req and init_ack is high, the register behaves normally.
- R12: irq_wake, irq_err and irq_ovr are the wake, change and overrun flags, each ANDed with wake_ie, err_ie and ovr_ie respectively.
- R13: A high overrun_evt sets bit 1 at the next edge, and a high rx_full_evt sets bit 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | 1 | Initialization mode request |
| init_ack | input | 1 | Initialization mode acknowledge |
| sleep_mode | input | 1 | Controller is in sleep mode |
| wake_en | input | 1 | Wake-up on bus activity enabled |
| bus_activity | input | 1 | Bus activity detected |
| overrun_evt | input | 1 | Receive overrun event pulse |
| rx_full_evt | input | 1 | Receive buffer full event pulse |
| tec | input | 9 | Transmit error count |
| rec | input | 9 | Receive error count |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data, one bit clears a flag |
| wake_ie | input | 1 | Wake interrupt enable |
| err_ie | input | 1 | Status change interrupt enable |
| ovr_ie | input | 1 | Overrun interrupt enable |
| rd_data | output | 8 | Register read value |
| irq_wake | output | 1 | Wake interrupt |
| irq_err | output | 1 | Status change interrupt |
| irq_ovr | output | 1 | Overrun interrupt |

## Verification
Counter changes, event pulses and writes each take effect at the first clock edge after they are applied, since every flag and captured level is one register deep. The interrupt outputs and rd_data follow those registers with no further delay. The bench drives every input one time unit after a rising edge and reads the outputs one time unit after the next rising edge, so each check sees exactly the edge it targets. Wherever a second edge matters, the bench steps one more clock and reads again. This covers the frozen levels while the change flag is set, and the renewed comparison after the flag is cleared.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;

    typedef enum logic [1:0] {
        LVL_OK      = 2'b00,
        LVL_WARN    = 2'b01,
        LVL_PASSIVE = 2'b10,
        LVL_OFF     = 2'b11
    } bus_lvl_e;

    typedef struct packed {
        logic     wake;
        logic     chg;
        bus_lvl_e rx;
        bus_lvl_e tx;
        logic     ovr;
        logic     rxf;
    } flag_reg_t;

    localparam int BIT_WAKE = 7;
    localparam int BIT_CHG  = 6;
    localparam int BIT_OVR  = 1;
    localparam int BIT_RXF  = 0;

    localparam int EVT_N    = 3;
    localparam int EVT_WAKE = 0;
    localparam int EVT_OVR  = 1;
    localparam int EVT_RXF  = 2;

    function automatic bus_lvl_e pick_level(input logic off, input logic passive,
                                            input logic warn);
        if (off)          return LVL_OFF;
        else if (passive) return LVL_PASSIVE;
        else if (warn)    return LVL_WARN;
        else              return LVL_OK;
    endfunction

endpackage

// File: rtl/cerr_lvl_enc.sv
module cerr_lvl_enc
    import can_stat_pkg::*;
#(
    parameter int CNT_W   = 9,
    parameter int WARN_AT = 96,
    parameter int PASS_AT = 128,
    parameter int OFF_AT  = 256,
    parameter bit IS_RX   = 1'b0
) (
    input  logic [CNT_W-1:0] tec,
    input  logic [CNT_W-1:0] rec,
    output bus_lvl_e         lvl
);
    localparam logic [CNT_W-1:0] WARN_C = CNT_W'(WARN_AT);
    localparam logic [CNT_W-1:0] PASS_C = CNT_W'(PASS_AT);
    localparam logic [CNT_W-1:0] OFF_C  = CNT_W'(OFF_AT);

    logic [CNT_W-1:0] own_cnt;
    logic             off, passive, warn;

    generate
        if (IS_RX) begin : g_rx
            assign own_cnt = rec;
        end else begin : g_tx
            assign own_cnt = tec;
        end
    endgenerate

    always_comb begin
        off     = (tec >= OFF_C);
        passive = (own_cnt >= PASS_C);
        warn    = (own_cnt >= WARN_C);
        lvl     = pick_level(off, passive, warn);
    end
endmodule

// File: rtl/cerr_stat_track.sv
module cerr_stat_track
    import can_stat_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     init_act,
    input  bus_lvl_e rx_now,
    input  bus_lvl_e tx_now,
    input  logic     clr_chg,
    output logic     chg,
    output bus_lvl_e rx_q,
    output bus_lvl_e tx_q
);
    logic differs;

    always_comb differs = (rx_now != rx_q) || (tx_now != tx_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            chg  <= 1'b0;
            rx_q <= LVL_OK;
            tx_q <= LVL_OK;
        end else if (init_act) begin
            chg <= 1'b0;
        end else if (!chg && differs) begin
            chg  <= 1'b1;
            rx_q <= rx_now;
            tx_q <= tx_now;
        end else if (clr_chg) begin
            chg <= 1'b0;
        end
    end
endmodule

// File: rtl/cerr_evt_flag.sv
module cerr_evt_flag (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst || hold) q <= 1'b0;
        else if (set_i)  q <= 1'b1;
        else if (clr_i)  q <= 1'b0;
    end
endmodule

// File: rtl/can_err_flag_reg.sv
module can_err_flag_reg
    import can_stat_pkg::*;
#(
    parameter int CNT_W   = 9,
    parameter int WARN_AT = 96,
    parameter int PASS_AT = 128,
    parameter int OFF_AT  = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init_req,
    input  logic             init_ack,
    input  logic             sleep_mode,
    input  logic             wake_en,
    input  logic             bus_activity,
    input  logic             overrun_evt,
    input  logic             rx_full_evt,
    input  logic [CNT_W-1:0] tec,
    input  logic [CNT_W-1:0] rec,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             wake_ie,
    input  logic             err_ie,
    input  logic             ovr_ie,
    output logic [7:0]       rd_data,
    output logic             irq_wake,
    output logic             irq_err,
    output logic             irq_ovr
);
    logic       init_act;
    logic       wr_ok;
    bus_lvl_e   rx_now, tx_now, rx_q, tx_q;
    logic       chg;
    logic [EVT_N-1:0] evt_set, evt_clr, evt_q;
    flag_reg_t  view;

    assign init_act = init_req && init_ack;
    assign wr_ok    = wr_en && !init_act;

    cerr_lvl_enc #(
        .CNT_W(CNT_W), .WARN_AT(WARN_AT), .PASS_AT(PASS_AT), .OFF_AT(OFF_AT), .IS_RX(1'b1)
    ) u_rx_enc (
        .tec(tec), .rec(rec), .lvl(rx_now)
    );

    cerr_lvl_enc #(
        .CNT_W(CNT_W), .WARN_AT(WARN_AT), .PASS_AT(PASS_AT), .OFF_AT(OFF_AT), .IS_RX(1'b0)
    ) u_tx_enc (
        .tec(tec), .rec(rec), .lvl(tx_now)
    );

    cerr_stat_track u_track (
        .clk     (clk),
        .rst     (rst),
        .init_act(init_act),
        .rx_now  (rx_now),
        .tx_now  (tx_now),
        .clr_chg (wr_ok && wr_data[BIT_CHG]),
        .chg     (chg),
        .rx_q    (rx_q),
        .tx_q    (tx_q)
    );

    always_comb begin
        evt_set[EVT_WAKE] = bus_activity && sleep_mode && wake_en;
        evt_set[EVT_OVR]  = overrun_evt;
        evt_set[EVT_RXF]  = rx_full_evt;
        evt_clr[EVT_WAKE] = wr_ok && wr_data[BIT_WAKE];
        evt_clr[EVT_OVR]  = wr_ok && wr_data[BIT_OVR];
        evt_clr[EVT_RXF]  = wr_ok && wr_data[BIT_RXF];
    end

    generate
        for (genvar i = 0; i < EVT_N; i++) begin : g_evt
            cerr_evt_flag u_flag (
                .clk  (clk),
                .rst  (rst),
                .hold (init_act),
                .set_i(evt_set[i]),
                .clr_i(evt_clr[i]),
                .q    (evt_q[i])
            );
        end
    endgenerate

    always_comb begin
        view.wake = evt_q[EVT_WAKE];
        view.chg  = chg;
        view.rx   = rx_q;
        view.tx   = tx_q;
        view.ovr  = evt_q[EVT_OVR];
        view.rxf  = evt_q[EVT_RXF];
        rd_data   = view;
        irq_wake  = view.wake && wake_ie;
        irq_err   = view.chg && err_ie;
        irq_ovr   = view.ovr && ovr_ie;
    end
endmodule

// File: rtl/can_err_flag_reg_chk.sv
module can_err_flag_reg_chk (
    input logic       clk,
    input logic       rst,
    input logic       init_req,
    input logic       init_ack,
    input logic       overrun_evt,
    input logic       rx_full_evt,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data
);
    // R6: captured levels stay put while the change flag remains set
    a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
        (rd_data[6] && $past(rd_data[6])) |-> $stable(rd_data[5:2]));

    // R2, R5: levels move only on the edge where the change flag rises
    a_r5_levels_move_on_rise: assert property (@(posedge clk) disable iff (rst)
        !$rose(rd_data[6]) |-> $stable(rd_data[5:2]));

    // R5: a rising change flag always brings a new level pair
    a_r5_rise_has_new_level: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data[6]) |-> (rd_data[5:2] != $past(rd_data[5:2])));

    // R11: initialization mode empties the flags
    a_r11_init_clears: assert property (@(posedge clk) disable iff (rst)
        (init_req && init_ack) |=> (rd_data[7:6] == 2'b00 && rd_data[1:0] == 2'b00));

    // R9, R13: an overrun event sets its flag even against a clear
    a_r9_ovr_set_wins: assert property (@(posedge clk) disable iff (rst)
        (overrun_evt && !(init_req && init_ack)) |=> rd_data[1]);

    // R9, R13: a receive-full event sets its flag even against a clear
    a_r13_rxf_set: assert property (@(posedge clk) disable iff (rst)
        (rx_full_evt && !(init_req && init_ack)) |=> rd_data[0]);

    // R8: writing one to the overrun bit clears it when no event competes
    a_r8_ovr_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[1] && !overrun_evt) |=> !rd_data[1]);
endmodule

bind can_err_flag_reg can_err_flag_reg_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .init_req   (init_req),
    .init_ack   (init_ack),
    .overrun_evt(overrun_evt),
    .rx_full_evt(rx_full_evt),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data)
);

// File: tb/can_err_flag_reg_bench.sv
`timescale 1ns/1ps
module can_err_flag_reg_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       init_req = 0, init_ack = 0, sleep_mode = 0, wake_en = 0;
    logic       bus_activity = 0, overrun_evt = 0, rx_full_evt = 0;
    logic [8:0] tec = 0, rec = 0;
    logic       wr_en = 0;
    logic [7:0] wr_data = 0;
    logic       wake_ie = 0, err_ie = 0, ovr_ie = 0;
    logic [7:0] rd_data;
    logic       irq_wake, irq_err, irq_ovr;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    can_err_flag_reg u_can_err_flag_reg (
        .clk(clk), .rst(rst), .init_req(init_req), .init_ack(init_ack),
        .sleep_mode(sleep_mode), .wake_en(wake_en), .bus_activity(bus_activity),
        .overrun_evt(overrun_evt), .rx_full_evt(rx_full_evt), .tec(tec), .rec(rec),
        .wr_en(wr_en), .wr_data(wr_data), .wake_ie(wake_ie), .err_ie(err_ie),
        .ovr_ie(ovr_ie), .rd_data(rd_data), .irq_wake(irq_wake), .irq_err(irq_err),
        .irq_ovr(irq_ovr)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        step();
        wr_en = 1'b0;
        wr_data = 8'h00;
    endtask

    // apply counters that change the level, check capture, then acknowledge
    task automatic apply_ack(input int t, input int r, input logic [1:0] erx,
                             input logic [1:0] etx, input string tag);
        tec = 9'(t);
        rec = 9'(r);
        step();
        check({tag, " R5 flag set"}, rd_data[6], 1);
        check({tag, " rx level"}, rd_data[5:4], erx);
        check({tag, " tx level"}, rd_data[3:2], etx);
        do_wr(8'h40);
        check({tag, " R8 flag cleared"}, rd_data[6], 0);
        step();
        check({tag, " R7 no re-set"}, rd_data[6], 0);
    endtask

    task automatic t_reset();
        check("R1 reset rd_data", rd_data, 8'h00);
        check("R1 reset irqs", {irq_wake, irq_err, irq_ovr}, 3'b000);
    endtask

    task automatic t_encoding();
        apply_ack(0,   96,  2'b01, 2'b00, "R3 rec=96");
        apply_ack(0,   128, 2'b10, 2'b00, "R3 rec=128");
        apply_ack(96,  128, 2'b10, 2'b01, "R4 tec=96");
        apply_ack(128, 10,  2'b00, 2'b10, "R4 tec=128");
        tec = 9'd255;
        step();
        check("R4 tec=255 stays passive", rd_data[6], 0);
        check("R4 tec=255 tx level", rd_data[3:2], 2'b10);
        apply_ack(256, 10, 2'b11, 2'b11, "R3 R4 bus off");
        apply_ack(0,   95, 2'b00, 2'b00, "R3 rec=95");
    endtask

    task automatic t_freeze();
        rec = 9'd100;
        step();
        check("R5 capture rx", rd_data[5:2], 4'b0100);
        rec = 9'd200;
        tec = 9'd130;
        step();
        check("R6 frozen after move", rd_data[5:2], 4'b0100);
        step();
        check("R6 still frozen", rd_data[5:2], 4'b0100);
        err_ie = 1'b1;
        #1;
        check("R12 irq_err on", irq_err, 1);
        err_ie = 1'b0;
        #1;
        check("R12 irq_err masked", irq_err, 0);
        do_wr(8'h40);
        check("R7 cleared edge", rd_data[6:2], 5'b00100);
        step();
        check("R7 re-set with new level", rd_data[6:2], 5'b11010);
        do_wr(8'hFF);
        check("R2 status read-only", rd_data[5:2], 4'b1010);
        check("R8 change flag cleared", rd_data[6], 0);
        apply_ack(0, 0, 2'b00, 2'b00, "R5 back to ok");
    endtask

    task automatic t_events();
        overrun_evt = 1'b1;
        step();
        overrun_evt = 1'b0;
        check("R13 overrun set", rd_data[1], 1);
        ovr_ie = 1'b1;
        #1;
        check("R12 irq_ovr", irq_ovr, 1);
        do_wr(8'h00);
        check("R8 zero write no effect", rd_data[1], 1);
        do_wr(8'h02);
        check("R8 overrun cleared", rd_data[1], 0);
        check("R12 irq_ovr low", irq_ovr, 0);
        ovr_ie = 1'b0;
        rx_full_evt = 1'b1;
        step();
        rx_full_evt = 1'b0;
        check("R13 rx full set", rd_data[0], 1);
        overrun_evt = 1'b1;
        do_wr(8'h03);
        overrun_evt = 1'b0;
        check("R9 set wins", rd_data[1:0], 2'b10);
        do_wr(8'h02);
        check("R8 overrun cleared again", rd_data[1], 0);
    endtask

    task automatic t_wake();
        bus_activity = 1'b1;
        step();
        check("R10 awake ignores activity", rd_data[7], 0);
        sleep_mode = 1'b1;
        step();
        check("R10 no enable ignores activity", rd_data[7], 0);
        wake_en = 1'b1;
        step();
        bus_activity = 1'b0;
        check("R10 wake set", rd_data[7], 1);
        wake_ie = 1'b1;
        #1;
        check("R12 irq_wake", irq_wake, 1);
        do_wr(8'h80);
        check("R8 wake cleared", rd_data[7], 0);
        wake_ie = 1'b0;
        sleep_mode = 1'b0;
        wake_en = 1'b0;
    endtask

    task automatic t_init();
        rec = 9'd100;
        step();
        check("R5 pre-init capture", rd_data[6:2], 5'b10100);
        overrun_evt = 1'b1;
        step();
        overrun_evt = 1'b0;
        init_req = 1'b1;
        step();
        check("R11 request alone keeps flags", {rd_data[6], rd_data[1]}, 2'b11);
        init_ack = 1'b1;
        step();
        check("R11 flags held zero", {rd_data[7:6], rd_data[1:0]}, 4'b0000);
        check("R11 status kept", rd_data[5:2], 4'b0100);
        rec = 9'd0;
        tec = 9'd200;
        overrun_evt = 1'b1;
        step();
        overrun_evt = 1'b0;
        check("R11 event ignored", rd_data[1], 0);
        check("R11 status not updated", rd_data[5:2], 4'b0100);
        init_req = 1'b0;
        init_ack = 1'b0;
        step();
        check("R11 exit re-evaluates", rd_data[6:2], 5'b10010);
        do_wr(8'h40);
        tec = 9'd0;
        step();
        check("R5 back to ok after init", rd_data[6:2], 5'b10000);
        do_wr(8'h40);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        step();
        step();
        rst = 1'b0;
        step();
        t_reset();
        t_encoding();
        t_freeze();
        t_events();
        t_wake();
        t_init();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule